// File: doc/BRIEF.md
# Bus Access Width Splitter

The splitter sits between the data port of a processor and a set of memory-mapped devices. These devices have data paths 8, 16 or 32 bits wide. It accepts one request of 8, 16 or 32 bits. It looks up which address region the request falls in, then breaks the request into as many narrow device transfers as the region's width needs. Each transfer is held for the number of clock cycles configured for that region. Read data from the transfers is assembled into one result. A one-cycle done strobe ends every request.

A 32-bit request carries only 24 useful bits. The top byte is driven as zero on writes and cleared on reads. The default map has three regions:

| Region | Address range | Device width | Write restriction |
|---|---|---|---|
| 0 | 0x0000–0x0FFF | 32-bit | none |
| 1 | 0x1000–0x1FFF | 8-bit | none |
| 2 | 0x8000–0xFFFF | 16-bit, non-volatile storage | accepts only 16-bit writes |

Other addresses are unmapped. The controller has three states:

- `ST_IDLE` waits for a request.
- `ST_XFER` drives the device transfers.
- `ST_FINISH` raises the done strobe.

It has five transitions:

- `T_ACCEPT` goes from `ST_IDLE` to `ST_XFER` when a valid request is legal.
- `T_REJECT` goes from `ST_IDLE` to `ST_FINISH` when a valid request is illegal.
- `T_NEXT` stays in `ST_XFER` while cycles or transfers remain.
- `T_LAST` goes from `ST_XFER` to `ST_FINISH` on the final cycle of the final transfer.
- `T_RETIRE` goes from `ST_FINISH` to `ST_IDLE`.

Top module: `bus_width_splitter`

## Requirements
- R1: While `rst_n` is low, and after its release until a request arrives, `busy`, `done`, `err` and `dev_en` are 0 and `rsp_rdata` is 0.
- R2: A request is taken on a rising edge where `req_valid` is 1 and `busy` is 0. A `req_valid` pulse while `busy` is 1 is ignored and is not queued: no transfer for it ever appears.
- R3: `req_size` codes are 0 for 8 bits, 1 for 16 and 2 for 32. The number of transfers depends on the device width:
    - On an 8-bit device, the sizes take 1, 2 and 4 transfers.
    - On a 16-bit device, they take 1, 1 and 2.
    - On a 32-bit device, each size takes 1.
- R4: Each transfer keeps `dev_en` high for C cycles. C is 1 plus the 2-bit code at bits [2i+1:2i] of `cfg_wait` for region i, sampled when the request is taken. `dev_en` is high for C×N consecutive cycles starting the cycle after acceptance. `done` pulses in the next cycle.
- R5: Transfers run lowest byte first. Transfer k uses `dev_addr` = request address + k × (device bytes). `dev_sel` is the region index.
- R6: On writes, transfer k carries request bytes k×W to k×W+W−1 right-justified on `dev_wdata`, where W is the device width in bytes. Lanes above the device width and bytes beyond the access size are 0. Byte 3 of a 32-bit write is 0. `dev_wdata` is 0 when `dev_we` is 0.
- R7: The bench's device returns its bytes right-justified on `dev_rdata`, and may return anything in lanes above its width. The block samples `dev_rdata` in the last cycle of each transfer and places it at byte offset k×W. It presents the zero-extended result on `rsp_rdata` in the done cycle. The top byte of a 32-bit read is 0. Writes return 0.
- R8: A write to region 2 whose size is not 16 bits pulses `done` and `err` together one cycle after acceptance and issues no transfer. Reads of any size from region 2 complete normally.
- R9: A request to an unmapped address, or with `req_size` = 3, is rejected the same way as in R8.
- R10: `busy` stays high from the cycle after acceptance through the done cycle and is low in the cycle after. `done` lasts one cycle. `err` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 16 | Byte address of the request |
| req_size | input | 2 | Access size code |
| req_we | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data, right-justified |
| cfg_wait | input | 6 | Per-region cycles-per-transfer codes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Request rejected (with done) |
| rsp_rdata | output | 32 | Assembled read data, valid with done |
| dev_en | output | 1 | Device transfer active |
| dev_we | output | 1 | Device transfer is a write |
| dev_sel | output | 2 | Index of the addressed region |
| dev_addr | output | 16 | Device transfer byte address |
| dev_wdata | output | 32 | Device write data, right-justified |
| dev_rdata | input | 32 | Device read data, right-justified |

## Verification
The bench's device fills every lane above the device's width with 0xEE. A splitter that forgot to mask by device width would leak that pattern into assembled reads. A 16-bit read from the 8-bit region with two cycles per transfer must take exactly four device cycles. A wrong transfer count or a wait counter that is off by one would shift `done` and fail the per-cycle comparison. The bench also covers three further corner cases:
- **32-bit writes and reads:** checked for a zero top byte.
- **Writes to the write-restricted region:** 8-bit and 32-bit writes must produce an error with no `dev_en` cycle, while a 16-bit write and reads of any size must not.
- **Requests raised while busy:** a stray request during a transfer must neither disturb the address sequence nor start a second access.

// File: rtl/bws_pkg.sv
package bws_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        DW_8  = 2'd0,
        DW_16 = 2'd1,
        DW_32 = 2'd2
    } dev_width_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_FINISH
    } seq_state_e;

    localparam int DATA_W = 32;

    // index of the final transfer (transfer count minus one)
    function automatic logic [1:0] last_xfer(input logic [1:0] devw, input logic [1:0] size);
        logic [1:0] diff;
        diff = size - devw;
        if (size <= devw)       return 2'd0;
        else if (diff == 2'd1)  return 2'd1;
        else                    return 2'd3;
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] size);
        case (size)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'h00FF_FFFF;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] devw);
        case (devw)
            DW_8:    return 32'h0000_00FF;
            DW_16:   return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/bws_decode.sv
module bws_decode
    import bws_pkg::*;
#(
    parameter int                 NREG     = 3,
    parameter int                 AW       = 16,
    parameter int                 RW       = 2,
    parameter logic [NREG*AW-1:0] REG_BASE = '0,
    parameter logic [NREG*AW-1:0] REG_LAST = '0,
    parameter logic [NREG*2-1:0]  REG_DEVW = '0
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [RW-1:0] idx,
    output logic [1:0]    devw
);

    logic [NREG-1:0] match;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_range
            assign match[g] = (addr >= REG_BASE[g*AW +: AW]) && (addr <= REG_LAST[g*AW +: AW]);
        end
    endgenerate

    // lowest-numbered matching region wins
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        devw = DW_32;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit  = 1'b1;
                idx  = RW'(i);
                devw = REG_DEVW[i*2 +: 2];
            end
        end
    end

endmodule

// File: rtl/bws_lanes.sv
module bws_lanes
    import bws_pkg::*;
(
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        size,
    input  logic [1:0]        devw,
    input  logic [1:0]        xfer,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [DATA_W-1:0] slice_wdata,
    output logic [DATA_W-1:0] rd_part
);

    logic [6:0]        shift;
    logic [DATA_W-1:0] amask;
    logic [DATA_W-1:0] dmask;

    always_comb begin
        shift       = 7'(xfer) << (7'd3 + 7'(devw));
        amask       = size_mask(size);
        dmask       = width_mask(devw);
        slice_wdata = ((wdata & amask) >> shift) & dmask;
        rd_part     = ((dev_rdata & dmask) << shift) & amask;
    end

endmodule

// File: rtl/bws_seq.sv
module bws_seq
    import bws_pkg::*;
#(
    parameter int NREG      = 3,
    parameter int AW        = 16,
    parameter int RW        = 2,
    parameter int FLASH_IDX = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [NREG*2-1:0] cfg_wait,
    input  logic              dec_hit,
    input  logic [RW-1:0]     dec_idx,
    input  logic [1:0]        dec_devw,
    input  logic [DATA_W-1:0] rd_part,
    output logic [DATA_W-1:0] lat_wdata,
    output logic [1:0]        lat_size,
    output logic [1:0]        lat_devw,
    output logic [1:0]        xfer,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dev_en,
    output logic              dev_we,
    output logic [RW-1:0]     dev_sel,
    output logic [AW-1:0]     dev_addr
);

    seq_state_e        state, state_nx;
    logic [AW-1:0]     lat_addr;
    logic              lat_we;
    logic [RW-1:0]     lat_reg;
    logic [1:0]        lat_cyc;
    logic [1:0]        lat_last;
    logic [1:0]        cnt;
    logic [DATA_W-1:0] rdacc;
    logic              err_q;
    logic              reject;
    logic              xfer_end;
    logic              xfer_final;

    assign reject = !dec_hit || (req_size == SZ_BAD)
                  || (req_we && (dec_idx == RW'(FLASH_IDX)) && (req_size != SZ_HALF));
    assign xfer_end   = (cnt == lat_cyc);
    assign xfer_final = xfer_end && (xfer == lat_last);

    // next-state logic: T_ACCEPT, T_REJECT, T_NEXT, T_LAST, T_RETIRE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = reject ? ST_FINISH : ST_XFER;
            ST_XFER:   if (xfer_final) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request context, counters and read assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_we    <= 1'b0;
            lat_wdata <= '0;
            lat_size  <= SZ_BYTE;
            lat_devw  <= DW_32;
            lat_reg   <= '0;
            lat_cyc   <= '0;
            lat_last  <= '0;
            cnt       <= '0;
            xfer      <= '0;
            rdacc     <= '0;
            err_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat_addr  <= req_addr;
                        lat_we    <= req_we;
                        lat_wdata <= req_wdata;
                        lat_size  <= req_size;
                        lat_devw  <= dec_devw;
                        lat_reg   <= dec_idx;
                        lat_cyc   <= cfg_wait[dec_idx*2 +: 2];
                        lat_last  <= last_xfer(dec_devw, req_size);
                        cnt       <= '0;
                        xfer      <= '0;
                        rdacc     <= '0;
                        err_q     <= reject;
                    end
                end
                ST_XFER: begin
                    if (xfer_end) begin
                        cnt  <= '0;
                        xfer <= xfer + 2'd1;
                        if (!lat_we) rdacc <= rdacc | rd_part;
                    end else begin
                        cnt <= cnt + 2'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_FINISH);
        err       = done && err_q;
        rsp_rdata = done ? rdacc : '0;
        dev_en    = (state == ST_XFER);
        dev_we    = dev_en && lat_we;
        dev_sel   = lat_reg;
        dev_addr  = lat_addr + (AW'(xfer) << lat_devw);
    end

endmodule

// File: rtl/bus_width_splitter.sv
module bus_width_splitter
    import bws_pkg::*;
#(
    parameter int                 NREG      = 3,
    parameter int                 AW        = 16,
    parameter int                 FLASH_IDX = 2,
    parameter logic [NREG*AW-1:0] REG_BASE  = {16'h8000, 16'h1000, 16'h0000},
    parameter logic [NREG*AW-1:0] REG_LAST  = {16'hFFFF, 16'h1FFF, 16'h0FFF},
    parameter logic [NREG*2-1:0]  REG_DEVW  = {2'd1, 2'd0, 2'd2},
    localparam int                RW        = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [NREG*2-1:0] cfg_wait,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dev_en,
    output logic              dev_we,
    output logic [RW-1:0]     dev_sel,
    output logic [AW-1:0]     dev_addr,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata
);

    logic              dec_hit;
    logic [RW-1:0]     dec_idx;
    logic [1:0]        dec_devw;
    logic [DATA_W-1:0] lat_wdata;
    logic [1:0]        lat_size;
    logic [1:0]        lat_devw;
    logic [1:0]        xfer;
    logic [DATA_W-1:0] slice_wdata;
    logic [DATA_W-1:0] rd_part;

    bws_decode #(
        .NREG(NREG), .AW(AW), .RW(RW),
        .REG_BASE(REG_BASE), .REG_LAST(REG_LAST), .REG_DEVW(REG_DEVW)
    ) u_decode (
        .addr (req_addr),
        .hit  (dec_hit),
        .idx  (dec_idx),
        .devw (dec_devw)
    );

    bws_seq #(
        .NREG(NREG), .AW(AW), .RW(RW), .FLASH_IDX(FLASH_IDX)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .cfg_wait  (cfg_wait),
        .dec_hit   (dec_hit),
        .dec_idx   (dec_idx),
        .dec_devw  (dec_devw),
        .rd_part   (rd_part),
        .lat_wdata (lat_wdata),
        .lat_size  (lat_size),
        .lat_devw  (lat_devw),
        .xfer      (xfer),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rsp_rdata (rsp_rdata),
        .dev_en    (dev_en),
        .dev_we    (dev_we),
        .dev_sel   (dev_sel),
        .dev_addr  (dev_addr)
    );

    bws_lanes u_lanes (
        .wdata       (lat_wdata),
        .size        (lat_size),
        .devw        (lat_devw),
        .xfer        (xfer),
        .dev_rdata   (dev_rdata),
        .slice_wdata (slice_wdata),
        .rd_part     (rd_part)
    );

    assign dev_wdata = dev_we ? slice_wdata : '0;

endmodule

// File: rtl/bws_chk.sv
module bws_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic err,
    input logic dev_en,
    input logic dev_we
);

    // R2: an accepted request makes the block busy on the next cycle
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R10: err only accompanies done
    p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R10: busy drops right after done, which makes done a single pulse
    p_done_retires_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    // R10: nothing happens on the device side while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!dev_en && !done));

    // R8: a rejected request issued no device transfer
    p_reject_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$past(dev_en));

    // R6: write strobe only within an active transfer
    p_we_in_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |-> dev_en);

endmodule

bind bus_width_splitter bws_chk u_chk (.*);

// File: tb/tb_bus_width_splitter.sv
module tb_bus_width_splitter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [15:0] req_addr;
    logic [1:0]  req_size;
    logic        req_we;
    logic [31:0] req_wdata;
    logic [5:0]  cfg_wait;
    logic        busy, done, err;
    logic [31:0] rsp_rdata;
    logic        dev_en, dev_we;
    logic [1:0]  dev_sel;
    logic [15:0] dev_addr;
    logic [31:0] dev_wdata;
    logic [31:0] dev_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_width_splitter dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_we(req_we), .req_wdata(req_wdata), .cfg_wait(cfg_wait),
        .busy(busy), .done(done), .err(err), .rsp_rdata(rsp_rdata),
        .dev_en(dev_en), .dev_we(dev_we), .dev_sel(dev_sel), .dev_addr(dev_addr),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic int region_of(input logic [15:0] a);
        if (a <= 16'h0FFF) return 0;
        if (a >= 16'h1000 && a <= 16'h1FFF) return 1;
        if (a >= 16'h8000) return 2;
        return -1;
    endfunction

    function automatic int region_bytes(input int r);
        return (r == 0) ? 4 : (r == 1) ? 1 : 2;
    endfunction

    // device model: true bytes in its own lanes, 0xEE junk above them
    always_comb begin
        for (int l = 0; l < 4; l++) begin
            if (l < region_bytes(int'(dev_sel)))
                dev_rdata[8*l +: 8] = mem_byte(dev_addr + 16'(l));
            else
                dev_rdata[8*l +: 8] = 8'hEE;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] addr, input logic [1:0] size, input bit we,
                       input logic [31:0] wdata, input bit poke);
        int r, ab, db, n, c;
        bit bad;
        logic [31:0] exp_r, exp_w;
        r   = region_of(addr);
        ab  = (size == 0) ? 1 : (size == 1) ? 2 : 4;
        bad = (r < 0) || (size == 2'd3) || (we && r == 2 && size != 2'd1);
        req_addr = addr; req_size = size; req_we = we; req_wdata = wdata; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (bad) begin
            chk(done === 1'b1 && err === 1'b1, "R8 R9 reject done+err", {30'd0, done, err}, 32'd3);
            chk(dev_en === 1'b0, "R8 R9 no transfer on reject", {31'd0, dev_en}, 32'd0);
            @(negedge clk);
            chk(busy === 1'b0 && dev_en === 1'b0, "R10 idle after reject", {30'd0, busy, dev_en}, 32'd0);
            return;
        end
        db = region_bytes(r);
        n  = (ab > db) ? ab / db : 1;
        c  = int'(cfg_wait[2*r +: 2]) + 1;
        exp_r = '0;
        for (int m = 0; m < ab; m++)
            if (!(size == 2 && m == 3)) exp_r[8*m +: 8] = mem_byte(addr + 16'(m));
        for (int t = 0; t < n; t++) begin
            exp_w = '0;
            for (int l = 0; l < db; l++) begin
                int bi;
                bi = t * db + l;
                if (bi < ab && !(size == 2 && bi == 3)) exp_w[8*l +: 8] = wdata[8*bi +: 8];
            end
            for (int j = 0; j < c; j++) begin
                chk(dev_en === 1'b1 && busy === 1'b1 && done === 1'b0, "R3 R4 transfer cycle active",
                    {29'd0, dev_en, busy, done}, 32'd6);
                chk(dev_addr === addr + 16'(t * db), "R5 transfer address", {16'd0, dev_addr},
                    {16'd0, addr + 16'(t * db)});
                chk(dev_sel === 2'(r), "R5 region select", {30'd0, dev_sel}, 32'(r));
                chk(dev_we === we, "R6 write strobe", {31'd0, dev_we}, {31'd0, we});
                chk(dev_wdata === (we ? exp_w : 32'd0), "R6 write slice", dev_wdata, we ? exp_w : 32'd0);
                if (poke && t == 0 && j == 0) begin
                    req_addr = 16'h0004; req_size = 2'd0; req_we = 1'b0; req_valid = 1'b1;
                end
                @(negedge clk);
                req_valid = 1'b0;
            end
        end
        chk(done === 1'b1 && err === 1'b0 && busy === 1'b1, "R4 R10 done after last cycle",
            {29'd0, done, err, busy}, 32'd5);
        chk(rsp_rdata === (we ? 32'd0 : exp_r), "R7 assembled read", rsp_rdata, we ? 32'd0 : exp_r);
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R10 idle after done", {30'd0, busy, done}, 32'd0);
        if (poke) begin
            @(negedge clk);
            chk(busy === 1'b0 && dev_en === 1'b0, "R2 request while busy not queued",
                {30'd0, busy, dev_en}, 32'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_we = 1'b0;
        req_wdata = '0;
        cfg_wait = {2'd3, 2'd1, 2'd0};   // region2: 4 cycles, region1: 2, region0: 1
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && err === 1'b0 && dev_en === 1'b0 && rsp_rdata === 32'd0,
            "R1 reset state", {28'd0, busy, done, err, dev_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && dev_en === 1'b0, "R1 idle after reset", {30'd0, busy, dev_en}, 32'd0);

        run(16'h0010, 2'd0, 1'b0, 32'd0, 1'b0);          // R3 byte read, 32-bit device
        run(16'h0100, 2'd2, 1'b0, 32'd0, 1'b0);          // R7 word read, top byte dropped
        run(16'h0202, 2'd1, 1'b1, 32'hAAAA_1234, 1'b0);  // R6 half write, 32-bit device
        run(16'h1020, 2'd1, 1'b0, 32'd0, 1'b0);          // R4 2 transfers x 2 cycles
        run(16'h1040, 2'd2, 1'b1, 32'hDEAD_BEEF, 1'b0);  // R6 4 byte transfers, top byte zero
        run(16'h1050, 2'd0, 1'b1, 32'h1234_5678, 1'b0);  // R3 single byte write
        run(16'h9000, 2'd2, 1'b0, 32'd0, 1'b0);          // R3 R8 word read of restricted region
        run(16'h9010, 2'd0, 1'b0, 32'd0, 1'b0);          // R8 byte read allowed
        run(16'h9020, 2'd1, 1'b1, 32'h0000_C3A5, 1'b0);  // R8 half write allowed
        run(16'h9030, 2'd0, 1'b1, 32'h0000_0011, 1'b0);  // R8 byte write rejected
        run(16'h9040, 2'd2, 1'b1, 32'h0102_0304, 1'b0);  // R8 word write rejected
        run(16'h4000, 2'd0, 1'b0, 32'd0, 1'b0);          // R9 unmapped
        run(16'h0020, 2'd3, 1'b0, 32'd0, 1'b0);          // R9 bad size code
        run(16'h1080, 2'd2, 1'b0, 32'd0, 1'b1);          // R2 poke while busy
        cfg_wait = {2'd0, 2'd3, 2'd2};                   // R4 new codes sampled at acceptance
        run(16'h0300, 2'd2, 1'b1, 32'hFF55_6677, 1'b0);
        run(16'h10F0, 2'd1, 1'b0, 32'd0, 1'b0);
        run(16'hA002, 2'd2, 1'b0, 32'd0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule